// File: doc/BRIEF.md
# Queued SPI Master Controller

This block is a serial peripheral master attached to a flat 32-bit register port. Software queues outgoing words in a transmit FIFO by writing a data register. A shift engine sends each queued word on the serial clock and data-out pins while it samples the data-in pin, and each captured word lands in a receive FIFO that software drains through a second data register. The word width and the serial clock divider are fixed when the block is elaborated; clock polarity, clock phase, bit order and an internal loopback path are picked at run time in the control register.

A hold bit in the control register stops the shift engine, so software can preload a burst and then release it to run back to back. The chip-select pins copy a software-written register bit for bit. Seven interrupt causes are latched in a write-one-to-clear status register, masked per cause and then by a global enable bit. Writing a key value to a reset register returns the whole block to its power-up state.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset the control register (0x60) reads 0x180 (hold bit8 and manual-select bit7 set), the status register (0x64) reads 0x05 (bit0 receive empty, bit2 transmit empty), the select register (0x70) reads all ones, interrupt status (0x20) reads 0, the interrupt pin is low and the serial clock is low.
- R2: With enable (bit1) and master (bit2) set, hold (bit8) clear, clock mode 0 and MSB-first order, a word written to 0x68 appears MSB first on the data-out pin, sampled by a slave on rising clock edges, and the word the slave returns on the data-in pin is read back from 0x6C.
- R3: While hold (bit8) is set no serial clock edge occurs and queued words stay in the transmit FIFO; clearing it sends every queued word back to back until the FIFO is empty.
- R4: With loopback (bit0) set, the data-out stream feeds the receive shifter, so each received word equals the transmitted word whatever the data-in pin does.
- R5: With LSB-first (bit9) set, bit 0 of a word is sent first and the first bit received becomes bit 0 of the received word.
- R6: Control bit3 sets the idle level of the serial clock; bit3 and bit4 together select one of four clock modes, each of which transfers a loopback word intact.
- R7: Status bit3 reports a full transmit FIFO; a write to 0x68 while it is full is discarded, so exactly DEPTH words are sent.
- R8: A word that completes while the receive FIFO is full is dropped, the stored words are kept, status bit1 reports full, and interrupt status bit5 is set.
- R9: Writing 1 to control bit5 or bit6 empties the transmit or receive FIFO; both bits read back as 0.
- R10: The select pins equal the low NUM_SS bits last written to 0x70.
- R11: Interrupt status bit2 is set when the last queued word finishes shifting, not when it leaves the FIFO; bit4 is set when the receive FIFO becomes full; bit6 is set when the transmit level falls to DEPTH/2 or below; writing 1 to a status bit clears it.
- R12: The interrupt pin is high exactly when bit31 of 0x1C is set and some status bit also enabled in 0x28 is set.
- R13: Writing 0x0A to 0x40 restores every register and empties both FIFOs; any other value written there has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (pops receive data at 0x6C) |
| regAddr | input | 8 | Register byte address |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for the addressed register, valid in the same cycle |
| spiSclk | output | 1 | Serial clock |
| spiMosi | output | 1 | Serial data out |
| spiMiso | input | 1 | Serial data in |
| spiSel | output | NUM_SS | Chip-select pins, copied from the select register |
| intrOut | output | 1 | Interrupt request |

## Verification
On every cycle the assertions check that the transmit and receive FIFO levels never exceed their depth, that a held and idle engine stays idle, that the serial clock rests at the chosen polarity between words, that a one written to an interrupt status bit clears it unless the same cause fires again, and that the key write restores the registers. What the wire actually carries in each clock mode and bit order, the timing of the transmit-empty cause against the final pop, overrun dropping, FIFO flushes and the interrupt gating can only be shown by the directed scenarios, which use a bench-side mode-0 slave and loopback.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
  localparam int ADDR_W = 8;
  localparam logic [ADDR_W-1:0] A_GIE  = 8'h1C;
  localparam logic [ADDR_W-1:0] A_ISR  = 8'h20;
  localparam logic [ADDR_W-1:0] A_IER  = 8'h28;
  localparam logic [ADDR_W-1:0] A_RST  = 8'h40;
  localparam logic [ADDR_W-1:0] A_CTRL = 8'h60;
  localparam logic [ADDR_W-1:0] A_STAT = 8'h64;
  localparam logic [ADDR_W-1:0] A_TXD  = 8'h68;
  localparam logic [ADDR_W-1:0] A_RXD  = 8'h6C;
  localparam logic [ADDR_W-1:0] A_SEL  = 8'h70;

  localparam int CTRL_W = 10;
  localparam int ISR_W  = 7;
  localparam logic [CTRL_W-1:0] CTRL_RST = 10'h180;
  localparam logic [31:0] RST_KEY = 32'h0000_000A;

  typedef struct packed {
    logic txPush;
    logic rxPop;
    logic txFlush;
    logic rxFlush;
    logic softRst;
  } spi_strobe_t;

  typedef struct packed {
    logic loopback;
    logic enable;
    logic master;
    logic cpol;
    logic cpha;
    logic inhibit;
    logic lsbFirst;
  } spi_cfg_t;

  typedef struct packed {
    logic txEmpty;
    logic txFull;
    logic txHalf;
    logic rxEmpty;
    logic rxFull;
    logic wordDone;
    logic rxDrop;
  } spi_stat_t;
endpackage

// File: rtl/spi_word_fifo.sv
module spi_word_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] wrData,
  input  logic             rdEn,
  output logic [WIDTH-1:0] rdData,
  output logic             empty,
  output logic             full,
  output logic [$clog2(DEPTH):0] level
);
  localparam int AW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic doWr, doRd;

  assign empty  = (level == '0);
  assign full   = (level == (AW+1)'(DEPTH));
  assign doWr   = wrEn && !full;
  assign doRd   = rdEn && !empty;
  assign rdData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doWr) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (doWr) wrPtr <= wrPtr + 1'b1;
      if (doRd) rdPtr <= rdPtr + 1'b1;
      case ({doWr, doRd})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  // R7
  fifo_no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    level <= (AW+1)'(DEPTH));
endmodule

// File: rtl/spi_fifo_dp.sv
module spi_fifo_dp
  import spi_fifo_pkg::*;
#(
  parameter int WORD_W  = 8,
  parameter int DEPTH   = 16,
  parameter int CLK_DIV = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  spi_strobe_t       strobe,
  input  spi_cfg_t          cfg,
  input  logic [WORD_W-1:0] txWord,
  output logic [WORD_W-1:0] rxHead,
  output spi_stat_t         stat,
  output logic              spiSclk,
  output logic              spiMosi,
  input  logic              spiMiso
);
  localparam int LAST_EDGE = 2*WORD_W - 1;
  localparam int EW = $clog2(2*WORD_W);
  localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int LW = $clog2(DEPTH) + 1;

  logic fifoRst;
  logic [WORD_W-1:0] txHead;
  logic txEmpty, txFull, rxEmpty, rxFull;
  logic [LW-1:0] txLevel, rxLevel;

  logic busy, sclkReg;
  logic [DW-1:0] divCnt;
  logic [EW-1:0] edgeCnt;
  logic [WORD_W-1:0] txShift, rxShift, rxNext;
  logic canStart, tick, leadEdge, sampleNow, shiftNow, lastEdge, inBit;

  assign fifoRst = !rstN || strobe.softRst;

  spi_word_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) txFifo (
    .clk(clk), .rstN(!fifoRst), .flush(strobe.txFlush),
    .wrEn(strobe.txPush), .wrData(txWord),
    .rdEn(canStart), .rdData(txHead),
    .empty(txEmpty), .full(txFull), .level(txLevel));

  spi_word_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) rxFifo (
    .clk(clk), .rstN(!fifoRst), .flush(strobe.rxFlush),
    .wrEn(lastEdge), .wrData(rxNext),
    .rdEn(strobe.rxPop), .rdData(rxHead),
    .empty(rxEmpty), .full(rxFull), .level(rxLevel));

  assign canStart = !busy && cfg.enable && cfg.master && !cfg.inhibit &&
                    !txEmpty && !strobe.txFlush && !strobe.softRst;
  assign tick     = busy && (divCnt == '0);
  assign leadEdge = !edgeCnt[0];
  assign sampleNow = tick && (cfg.cpha ? !leadEdge : leadEdge);
  assign shiftNow  = tick && (cfg.cpha ? (leadEdge && edgeCnt != '0)
                                       : (!leadEdge && edgeCnt != EW'(LAST_EDGE)));
  assign lastEdge  = tick && (edgeCnt == EW'(LAST_EDGE));
  assign spiMosi   = cfg.lsbFirst ? txShift[0] : txShift[WORD_W-1];
  assign inBit     = cfg.loopback ? spiMosi : spiMiso;
  assign spiSclk   = sclkReg;

  always_comb begin
    rxNext = rxShift;
    if (sampleNow)
      rxNext = cfg.lsbFirst ? {inBit, rxShift[WORD_W-1:1]}
                            : {rxShift[WORD_W-2:0], inBit};
  end

  always_ff @(posedge clk) begin
    if (fifoRst) begin
      busy    <= 1'b0;
      sclkReg <= 1'b0;
      divCnt  <= '0;
      edgeCnt <= '0;
      txShift <= '0;
      rxShift <= '0;
    end else if (canStart) begin
      busy    <= 1'b1;
      txShift <= txHead;
      divCnt  <= DW'(CLK_DIV-1);
      edgeCnt <= '0;
      sclkReg <= cfg.cpol;
    end else if (busy) begin
      if (tick) begin
        divCnt  <= DW'(CLK_DIV-1);
        sclkReg <= !sclkReg;
        edgeCnt <= edgeCnt + 1'b1;
        rxShift <= rxNext;
        if (shiftNow)
          txShift <= cfg.lsbFirst ? (txShift >> 1) : (txShift << 1);
        if (lastEdge) busy <= 1'b0;
      end else begin
        divCnt <= divCnt - 1'b1;
      end
    end else begin
      sclkReg <= cfg.cpol;
    end
  end

  always_comb begin
    stat.txEmpty  = txEmpty;
    stat.txFull   = txFull;
    stat.txHalf   = (txLevel <= LW'(DEPTH/2));
    stat.rxEmpty  = rxEmpty;
    stat.rxFull   = rxFull;
    stat.wordDone = lastEdge;
    stat.rxDrop   = lastEdge && rxFull;
  end

  // R3
  inhibit_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.inhibit && !busy) |=> !busy);

  // R6
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && $past(!busy) && $stable(cfg.cpol)) |-> (spiSclk == cfg.cpol));

  // R7
  rx_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxLevel <= LW'(DEPTH));
endmodule

// File: rtl/spi_fifo_ctrl.sv
module spi_fifo_ctrl
  import spi_fifo_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int NUM_SS = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic [WORD_W-1:0] rxHead,
  input  spi_stat_t         stat,
  output spi_strobe_t       strobe,
  output spi_cfg_t          cfg,
  output logic [NUM_SS-1:0] spiSel,
  output logic              intrOut
);
  logic [CTRL_W-1:0] ctrlReg;
  logic [NUM_SS-1:0] selReg;
  logic [ISR_W-1:0]  isrReg, ierReg, setEv, clrMask;
  logic gieBit, rxFullPrev, txHalfPrev;
  logic wrCtrl, wrIsr;

  assign wrCtrl = regWrEn && (regAddr == A_CTRL);
  assign wrIsr  = regWrEn && (regAddr == A_ISR);

  always_comb begin
    strobe.txPush  = regWrEn && (regAddr == A_TXD);
    strobe.rxPop   = regRdEn && (regAddr == A_RXD);
    strobe.txFlush = wrCtrl && regWrData[5];
    strobe.rxFlush = wrCtrl && regWrData[6];
    strobe.softRst = regWrEn && (regAddr == A_RST) && (regWrData == RST_KEY);
  end

  always_comb begin
    cfg.loopback = ctrlReg[0];
    cfg.enable   = ctrlReg[1];
    cfg.master   = ctrlReg[2];
    cfg.cpol     = ctrlReg[3];
    cfg.cpha     = ctrlReg[4];
    cfg.inhibit  = ctrlReg[8];
    cfg.lsbFirst = ctrlReg[9];
  end

  always_comb begin
    setEv    = '0;
    setEv[2] = stat.wordDone && stat.txEmpty && !strobe.txPush;
    setEv[4] = stat.rxFull && !rxFullPrev;
    setEv[5] = stat.rxDrop;
    setEv[6] = stat.txHalf && !txHalfPrev;
    clrMask  = wrIsr ? regWrData[ISR_W-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.softRst) begin
      ctrlReg    <= CTRL_RST;
      selReg     <= '1;
      isrReg     <= '0;
      ierReg     <= '0;
      gieBit     <= 1'b0;
      rxFullPrev <= 1'b0;
      txHalfPrev <= 1'b1;
    end else begin
      rxFullPrev <= stat.rxFull;
      txHalfPrev <= stat.txHalf;
      isrReg     <= (isrReg & ~clrMask) | setEv;
      if (wrCtrl) ctrlReg <= regWrData[CTRL_W-1:0] & ~CTRL_W'(10'h060);
      if (regWrEn && regAddr == A_SEL) selReg <= regWrData[NUM_SS-1:0];
      if (regWrEn && regAddr == A_IER) ierReg <= regWrData[ISR_W-1:0];
      if (regWrEn && regAddr == A_GIE) gieBit <= regWrData[31];
    end
  end

  assign spiSel  = selReg;
  assign intrOut = gieBit && |(isrReg & ierReg);

  always_comb begin
    regRdData = '0;
    case (regAddr)
      A_CTRL: regRdData[CTRL_W-1:0] = ctrlReg;
      A_STAT: regRdData[4:0] = {1'b0, stat.txFull, stat.txEmpty,
                                stat.rxFull, stat.rxEmpty};
      A_RXD:  regRdData[WORD_W-1:0] = rxHead;
      A_SEL:  regRdData[NUM_SS-1:0] = selReg;
      A_ISR:  regRdData[ISR_W-1:0] = isrReg;
      A_IER:  regRdData[ISR_W-1:0] = ierReg;
      A_GIE:  regRdData[31] = gieBit;
      default: regRdData = '0;
    endcase
  end

  // R11
  isr_w1c_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrIsr |=> ((isrReg & $past(regWrData[ISR_W-1:0] & ~setEv)) == '0));

  // R13
  soft_rst_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.softRst |=> (ctrlReg == CTRL_RST && selReg == '1 && isrReg == '0 && !gieBit));

  // R9
  flush_bits_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrCtrl |=> (ctrlReg[6:5] == 2'b00));
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
  import spi_fifo_pkg::*;
#(
  parameter int WORD_W  = 8,
  parameter int DEPTH   = 16,
  parameter int CLK_DIV = 2,
  parameter int NUM_SS  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [7:0]        regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic              spiSclk,
  output logic              spiMosi,
  input  logic              spiMiso,
  output logic [NUM_SS-1:0] spiSel,
  output logic              intrOut
);
  spi_strobe_t strobe;
  spi_cfg_t    cfg;
  spi_stat_t   stat;
  logic [WORD_W-1:0] rxHead;

  spi_fifo_ctrl #(.WORD_W(WORD_W), .NUM_SS(NUM_SS)) ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .rxHead(rxHead), .stat(stat), .strobe(strobe), .cfg(cfg),
    .spiSel(spiSel), .intrOut(intrOut));

  spi_fifo_dp #(.WORD_W(WORD_W), .DEPTH(DEPTH), .CLK_DIV(CLK_DIV)) dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfg(cfg),
    .txWord(regWrData[WORD_W-1:0]), .rxHead(rxHead), .stat(stat),
    .spiSclk(spiSclk), .spiMosi(spiMosi), .spiMiso(spiMiso));
endmodule

// File: tb/spi_fifo_master_test.sv
`timescale 1ns/1ps
module spi_fifo_master_test;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0, regRdEn = 1'b0;
  logic [7:0] regAddr = '0;
  logic [31:0] regWrData = '0, regRdData;
  logic spiSclk, spiMosi, spiMiso, intrOut;
  logic [7:0] spiSel;

  int checks = 0, failures = 0, sclkToggles = 0;
  bit done = 0;

  logic [7:0] slvRx = '0, slvTx = '0, slvSeed = '0;
  logic slvLoad = 1'b0;

  always #4 clk = ~clk;

  spi_fifo_master uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .spiSclk(spiSclk), .spiMosi(spiMosi), .spiMiso(spiMiso),
    .spiSel(spiSel), .intrOut(intrOut));

  // mode-0 slave: capture on rising, advance on falling
  assign spiMiso = slvTx[7];
  always @(posedge spiSclk) slvRx <= {slvRx[6:0], spiMosi};
  always @(negedge spiSclk or posedge slvLoad)
    if (slvLoad) slvTx <= slvSeed;
    else slvTx <= {slvTx[6:0], 1'b0};
  always @(spiSclk) sclkToggles++;

  task automatic checkEq(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic loadSlave(input logic [7:0] s);
    slvSeed = s;
    #1 slvLoad = 1'b1;
    #1 slvLoad = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic testReset();
    logic [31:0] d;
    regRead(8'h60, d); checkEq("R1 ctrl", d, 32'h180);
    regRead(8'h64, d); checkEq("R1 status", d, 32'h05);
    regRead(8'h70, d); checkEq("R1 select", d, 32'hFF);
    regRead(8'h20, d); checkEq("R1 isr", d, 0);
    checkEq("R1 irq", intrOut, 0);
    checkEq("R1 sclk", spiSclk, 0);
  endtask

  task automatic testMode0();
    logic [31:0] d;
    regWrite(8'h70, 32'hFE);
    idle(1); checkEq("R10 select pins", spiSel, 8'hFE);
    regWrite(8'h70, 32'h5B);
    idle(1); checkEq("R10 select pins", spiSel, 8'h5B);
    regWrite(8'h60, 32'h086);
    loadSlave(8'h3C);
    regWrite(8'h68, 32'hA5);
    idle(60);
    checkEq("R2 slave saw", slvRx, 8'hA5);
    regRead(8'h6C, d); checkEq("R2 rx word", d, 32'h3C);
    loadSlave(8'h81);
    regWrite(8'h68, 32'h5A);
    idle(60);
    checkEq("R2 slave saw", slvRx, 8'h5A);
    regRead(8'h6C, d); checkEq("R2 rx word", d, 32'h81);
  endtask

  task automatic testInhibit();
    logic [31:0] d;
    int t0;
    regWrite(8'h60, 32'h187);
    t0 = sclkToggles;
    regWrite(8'h68, 32'h11); regWrite(8'h68, 32'h22); regWrite(8'h68, 32'h33);
    idle(200);
    checkEq("R3 no clock while held", sclkToggles - t0, 0);
    regRead(8'h64, d); checkEq("R3 words kept", d, 32'h01);
    regWrite(8'h60, 32'h087);
    idle(160);
    regRead(8'h6C, d); checkEq("R4 loop word0", d, 32'h11);
    regRead(8'h6C, d); checkEq("R4 loop word1", d, 32'h22);
    regRead(8'h6C, d); checkEq("R3 burst drained", d, 32'h33);
    regRead(8'h64, d); checkEq("R3 empty after", d, 32'h05);
  endtask

  task automatic testModes();
    logic [31:0] d;
    for (int m = 0; m < 4; m++) begin
      regWrite(8'h60, 32'h087 | (m << 3));
      idle(3);
      checkEq("R6 idle level", spiSclk, m & 1);
      regWrite(8'h68, 32'hC3 ^ m);
      idle(60);
      checkEq("R6 idle after word", spiSclk, m & 1);
      regRead(8'h6C, d); checkEq("R6 R4 loop mode", d, 32'hC3 ^ m);
    end
  endtask

  task automatic testLsb();
    logic [31:0] d;
    regWrite(8'h60, 32'h286);
    idle(3);
    loadSlave(8'h0A);
    regWrite(8'h68, 32'h03);
    idle(60);
    checkEq("R5 wire order", slvRx, 8'hC0);
    regRead(8'h6C, d); checkEq("R5 rx order", d, 32'h50);
  endtask

  task automatic testTxFull();
    logic [31:0] d;
    regWrite(8'h20, 32'h7F);
    regWrite(8'h60, 32'h187);
    for (int i = 1; i <= DEPTH + 1; i++) regWrite(8'h68, i);
    regRead(8'h64, d); checkEq("R7 full flag", d, 32'h09);
    regWrite(8'h60, 32'h087);
    idle(700);
    for (int i = 1; i <= DEPTH; i++) begin
      regRead(8'h6C, d); checkEq("R7 queued word", d, i);
    end
    regRead(8'h64, d); checkEq("R7 extra dropped", d, 32'h05);
    regRead(8'h20, d); checkEq("R11 causes", d, 32'h54);
  endtask

  task automatic testOverrun();
    logic [31:0] d;
    regWrite(8'h20, 32'h7F);
    regWrite(8'h60, 32'h187);
    for (int i = 0; i < DEPTH; i++) regWrite(8'h68, 32'h40 + i);
    regWrite(8'h60, 32'h087);
    idle(700);
    regRead(8'h64, d); checkEq("R8 rx full", d, 32'h06);
    regWrite(8'h68, 32'h99);
    idle(60);
    regRead(8'h20, d); checkEq("R8 overrun bit", d & 32'h20, 32'h20);
    for (int i = 0; i < DEPTH; i++) begin
      regRead(8'h6C, d); checkEq("R8 kept word", d, 32'h40 + i);
    end
    regRead(8'h64, d); checkEq("R8 dropped", d, 32'h05);
  endtask

  task automatic testFlush();
    logic [31:0] d;
    regWrite(8'h60, 32'h187);
    regWrite(8'h68, 32'h01); regWrite(8'h68, 32'h02);
    regRead(8'h64, d); checkEq("R9 tx loaded", d, 32'h01);
    regWrite(8'h60, 32'h1A7);
    regRead(8'h60, d); checkEq("R9 bits self clear", d, 32'h187);
    regRead(8'h64, d); checkEq("R9 tx flushed", d, 32'h05);
    regWrite(8'h60, 32'h087);
    regWrite(8'h68, 32'h0E); regWrite(8'h68, 32'h0F);
    idle(100);
    regRead(8'h64, d); checkEq("R9 rx loaded", d, 32'h04);
    regWrite(8'h60, 32'h0C7);
    regRead(8'h64, d); checkEq("R9 rx flushed", d, 32'h05);
  endtask

  task automatic testIrq();
    logic [31:0] d;
    regWrite(8'h20, 32'h7F);
    regWrite(8'h28, 32'h04);
    regWrite(8'h60, 32'h187);
    regWrite(8'h68, 32'h71); regWrite(8'h68, 32'h72); regWrite(8'h68, 32'h73);
    regWrite(8'h60, 32'h087);
    idle(78);
    regRead(8'h64, d); checkEq("R11 fifo already empty", d & 32'h04, 32'h04);
    regRead(8'h20, d); checkEq("R11 not set at pop", d, 32'h00);
    idle(60);
    regRead(8'h20, d); checkEq("R11 set at finish", d, 32'h04);
    checkEq("R12 global off", intrOut, 0);
    regWrite(8'h1C, 32'h8000_0000);
    idle(1); checkEq("R12 asserted", intrOut, 1);
    regWrite(8'h28, 32'h00);
    idle(1); checkEq("R12 masked", intrOut, 0);
    regWrite(8'h28, 32'h04);
    idle(1); checkEq("R12 unmasked", intrOut, 1);
    regWrite(8'h20, 32'h04);
    regRead(8'h20, d); checkEq("R11 w1c", d, 32'h00);
    checkEq("R12 cleared", intrOut, 0);
    regWrite(8'h60, 32'h0C7);
  endtask

  task automatic testSoftReset();
    logic [31:0] d;
    regWrite(8'h60, 32'h086);
    regWrite(8'h70, 32'h00);
    regWrite(8'h28, 32'h7F);
    regWrite(8'h40, 32'h05);
    regRead(8'h60, d); checkEq("R13 ignored ctrl", d, 32'h086);
    regRead(8'h28, d); checkEq("R13 ignored ier", d, 32'h7F);
    regWrite(8'h40, 32'h0A);
    regRead(8'h60, d); checkEq("R13 ctrl", d, 32'h180);
    regRead(8'h70, d); checkEq("R13 select", d, 32'hFF);
    regRead(8'h28, d); checkEq("R13 ier", d, 32'h00);
    regRead(8'h1C, d); checkEq("R13 gie", d, 32'h00);
    regRead(8'h64, d); checkEq("R13 status", d, 32'h05);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    idle(2);
    testReset();
    testMode0();
    testInhibit();
    testModes();
    testLsb();
    testTxFull();
    testOverrun();
    testFlush();
    testIrq();
    testSoftReset();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule